// File: doc/BRIEF.md
# Three-Channel Timer Command and Readback Port

This block is the byte-wide programming front end of a three-channel interval timer. Software reaches it through a small synchronous register bus: three data addresses, one per channel, and one command address. A command byte picks a channel and stores that channel's byte-access style, operating mode and BCD flag. It can also freeze a channel's count so that it can be read. A read-back command freezes counts and status bytes on several channels in one write.

The counting engines sit outside this block. Each one hands in its live count, its output pin level and its null-count flag. In return it receives its committed reload value with a one-cycle load pulse, its stored mode and BCD setting, and a one-cycle pulse whenever a new configuration is written. Data-port writes are assembled into 16-bit reload values according to the channel's access style. Data-port reads are served from a pending status byte, a frozen count or the live count, in that order of preference.

Top module: `timer_cmd_if`

## Requirements
- R1: Address 0, 1 and 2 are the data ports of channels 0, 1 and 2, and address 3 is the command port. A read at address 3 returns 0x00. A write strobe and a read strobe are never asserted in the same cycle.
- R2: A command whose bits [7:6] are 0, 1 or 2 selects that channel. If bits [5:4] are non-zero, the command stores them as the access style (01 low byte only, 10 high byte only, 11 low then high), stores [3:1] as the mode and [0] as the BCD flag, and pulses `cfg_wr` for that channel alone in the following cycle. After reset every channel has style 11, mode 0, BCD 0 and reload 0.
- R3: In low-only style, a data write sets the reload to {0x00, byte}. In high-only style, it sets the reload to {byte, 0x00}. The new reload value and its `reload_load` pulse appear in the cycle after the write.
- R4: In low-then-high style, the first data write only stores the low byte, with no load pulse. The second write commits {second, first} and pulses the load.
- R5: When nothing is frozen, a data read returns the live count: the low byte in low-only style, the high byte in high-only style, and the low byte then the high byte on alternating reads in low-then-high style.
- R6: A command with bits [5:4] = 00 freezes the selected channel's count at the cycle of the command. Reads then return the frozen value, regardless of later count changes, until its bytes for the channel's style have all been read. After that, reads return the live count again.
- R7: A command with bits [7:6] = 11 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2, in any combination. Bit 5 = 0 freezes the count of each selected channel. Bit 4 = 0 freezes the status byte of each selected channel.
- R8: The status byte is {output level, null-count flag, style[1:0], mode[2:0], BCD}, captured at the read-back cycle. The next data read of that channel returns it, and that one read consumes it.
- R9: When a channel has both a frozen status byte and a frozen count, the status byte is read first and the count bytes follow, low byte first.
- R10: A configuration command releases any frozen count and status byte on its channel and resets both byte pointers to the low byte. Any count freeze resets that channel's read pointer to the low byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; the read side effects happen at this edge |
| bus_rdata | output | 8 | Read data for the addressed port |
| cnt_in | input | 48 | Live counts of the three channels, channel 0 in the low 16 bits |
| out_in | input | 3 | Output pin level of each channel |
| null_in | input | 3 | Null-count flag of each channel |
| reload_out | output | 48 | Committed reload value of each channel |
| reload_load | output | 3 | One-cycle pulse when a channel's reload value is committed |
| ch_mode | output | 9 | Stored operating mode, 3 bits per channel |
| ch_bcd | output | 3 | Stored BCD flag per channel |
| cfg_wr | output | 3 | One-cycle pulse after a configuration command for a channel |

## Verification
The assertions check several rules on every cycle. Strobes never overlap. A single-byte write commits exactly the expected reload in the next cycle, and a first low byte never commits. A frozen count stays untouched between commands. A configuration command leaves nothing frozen. A read-back captures the output level into the status byte. Reading a status byte consumes it and leaves any frozen count in place.

Byte ordering across several reads can only be shown by the bench's scenarios. These cover a count that changes after being frozen, a half-finished low/high write interrupted by a new command, and a re-freeze after one byte was read. They also cover read-backs that mix status and count across more than one channel.

// File: rtl/timer_cmd_if.sv
module timer_cmd_if #(
  parameter int NCH = 3,
  parameter int CW  = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic [NCH*CW-1:0] cnt_in,
  input  logic [NCH-1:0]    out_in,
  input  logic [NCH-1:0]    null_in,
  output logic [NCH*CW-1:0] reload_out,
  output logic [NCH-1:0]    reload_load,
  output logic [NCH*3-1:0]  ch_mode,
  output logic [NCH-1:0]    ch_bcd,
  output logic [NCH-1:0]    cfg_wr
);
  localparam int HB = CW / 2;

  logic [1:0]    acc_q  [NCH];
  logic [2:0]    mode_q [NCH];
  logic          bcd_q  [NCH];
  logic [CW-1:0] rel_q  [NCH];
  logic [HB-1:0] lo_q   [NCH];
  logic          wptr_q [NCH];
  logic          rptr_q [NCH];
  logic [CW-1:0] lat_q  [NCH];
  logic          clat_q [NCH];
  logic          slat_q [NCH];
  logic [7:0]    stat_q [NCH];
  logic [NCH-1:0] load_q, cfgp_q;

  logic [CW-1:0] live  [NCH];
  logic [7:0]    rbyte [NCH];
  logic [NCH-1:0] cw_hit, lt_hit, rbc_hit, rbs_hit, dw_hit, dr_hit;

  wire       cmd_wr = bus_wr && (bus_addr == 2'd3);
  wire [1:0] sel    = bus_wdata[7:6];
  wire       rb     = (sel == 2'b11);
  wire [1:0] wacc   = bus_wdata[5:4];

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      live[i]    = cnt_in[CW*i +: CW];
      cw_hit[i]  = cmd_wr && !rb && (sel == 2'(i)) && (wacc != 2'b00);
      lt_hit[i]  = cmd_wr && !rb && (sel == 2'(i)) && (wacc == 2'b00);
      rbc_hit[i] = cmd_wr && rb && bus_wdata[i+1] && !bus_wdata[5];
      rbs_hit[i] = cmd_wr && rb && bus_wdata[i+1] && !bus_wdata[4];
      dw_hit[i]  = bus_wr && (bus_addr == 2'(i));
      dr_hit[i]  = bus_rd && (bus_addr == 2'(i));
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      logic [CW-1:0] src;
      src = clat_q[i] ? lat_q[i] : live[i];
      if (slat_q[i])
        rbyte[i] = stat_q[i];
      else if (acc_q[i] == 2'b10 || (acc_q[i] == 2'b11 && rptr_q[i]))
        rbyte[i] = src[CW-1:HB];
      else
        rbyte[i] = src[HB-1:0];
    end
    bus_rdata = 8'h00;
    for (int i = 0; i < NCH; i++)
      if (bus_addr == 2'(i)) bus_rdata = rbyte[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cfgp_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        acc_q[i]  <= 2'b11;
        mode_q[i] <= 3'd0;
        bcd_q[i]  <= 1'b0;
        rel_q[i]  <= '0;
        lo_q[i]   <= '0;
        wptr_q[i] <= 1'b0;
        rptr_q[i] <= 1'b0;
        lat_q[i]  <= '0;
        clat_q[i] <= 1'b0;
        slat_q[i] <= 1'b0;
        stat_q[i] <= 8'h00;
      end
    end else begin
      load_q <= '0;
      cfgp_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        if (cw_hit[i]) begin
          acc_q[i]  <= wacc;
          mode_q[i] <= bus_wdata[3:1];
          bcd_q[i]  <= bus_wdata[0];
          wptr_q[i] <= 1'b0;
          rptr_q[i] <= 1'b0;
          clat_q[i] <= 1'b0;
          slat_q[i] <= 1'b0;
          cfgp_q[i] <= 1'b1;
        end
        if (lt_hit[i] || rbc_hit[i]) begin
          lat_q[i]  <= live[i];
          clat_q[i] <= 1'b1;
          rptr_q[i] <= 1'b0;
        end
        if (rbs_hit[i]) begin
          stat_q[i] <= {out_in[i], null_in[i], acc_q[i], mode_q[i], bcd_q[i]};
          slat_q[i] <= 1'b1;
        end
        if (dw_hit[i]) begin
          case (acc_q[i])
            2'b01: begin rel_q[i] <= {{HB{1'b0}}, bus_wdata}; load_q[i] <= 1'b1; end
            2'b10: begin rel_q[i] <= {bus_wdata, {HB{1'b0}}}; load_q[i] <= 1'b1; end
            2'b11: begin
              if (!wptr_q[i]) begin
                lo_q[i]   <= bus_wdata;
                wptr_q[i] <= 1'b1;
              end else begin
                rel_q[i]  <= {bus_wdata, lo_q[i]};
                wptr_q[i] <= 1'b0;
                load_q[i] <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        if (dr_hit[i]) begin
          if (slat_q[i])
            slat_q[i] <= 1'b0;
          else if (acc_q[i] == 2'b11) begin
            rptr_q[i] <= ~rptr_q[i];
            if (rptr_q[i]) clat_q[i] <= 1'b0;
          end else
            clat_q[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      reload_out[CW*i +: CW] = rel_q[i];
      ch_mode[3*i +: 3]      = mode_q[i];
      ch_bcd[i]              = bcd_q[i];
    end
  end
  assign reload_load = load_q;
  assign cfg_wr      = cfgp_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd)); // R1

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (dw_hit[g] && (acc_q[g] == 2'b01 || acc_q[g] == 2'b10)) |=>
        (reload_load[g] && reload_out[CW*g +: CW] ==
          (($past(acc_q[g]) == 2'b01) ? {8'h00, $past(bus_wdata)} : {$past(bus_wdata), 8'h00}))); // R3
    AST_LOW_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dw_hit[g] && acc_q[g] == 2'b11 && !wptr_q[g]) |=>
        (!reload_load[g] && $stable(reload_out[CW*g +: CW]))); // R4
    AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (clat_q[g] && !cmd_wr) |=> $stable(lat_q[g])); // R6
    AST_STATUS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      rbs_hit[g] |=> (slat_q[g] && stat_q[g][7] == $past(out_in[g]))); // R8
    AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_hit[g] && slat_q[g]) |=> (!slat_q[g] && clat_q[g] == $past(clat_q[g]))); // R9
    AST_CFG_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      cw_hit[g] |=> (!clat_q[g] && !slat_q[g] && !wptr_q[g] && !rptr_q[g])); // R10
  end
endmodule

// File: tb/tb_timer_cmd_if.sv
`timescale 1ns/1ps
module tb_timer_cmd_if;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_rdata;
  logic [47:0] cnt_in;
  logic [2:0]  out_in, null_in;
  logic [47:0] reload_out;
  logic [2:0]  reload_load;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;
  logic [2:0]  cfg_wr;

  always #4 clk = ~clk;

  logic [15:0] cnt [3];
  assign cnt_in = {cnt[2], cnt[1], cnt[0]};

  timer_cmd_if dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cnt_in(cnt_in), .out_in(out_in), .null_in(null_in),
    .reload_out(reload_out), .reload_load(reload_load),
    .ch_mode(ch_mode), .ch_bcd(ch_bcd), .cfg_wr(cfg_wr)
  );

  int checks = 0, errors = 0;
  bit run = 0;
  int m_acc[3], m_mode[3], m_bcd[3], m_rel[3], m_lo[3], m_wp[3], m_rp[3];
  int m_lat[3], m_cl[3], m_sl[3], m_st[3];

  task automatic chk(string r, int act, int exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  always @(negedge clk) if (run) begin
    for (int c = 0; c < 3; c++) begin
      chk("R3", int'(reload_out[16*c +: 16]), m_rel[c], "reload value");
      chk("R2", int'(ch_mode[3*c +: 3]), m_mode[c], "stored mode");
      chk("R2", int'(ch_bcd[c]), m_bcd[c], "stored bcd");
    end
  end

  task automatic freeze(int c);
    m_lat[c] = cnt[c]; m_cl[c] = 1; m_rp[c] = 0;
  endtask

  task automatic cmd(input logic [7:0] b);
    int s, ecfg;
    @(negedge clk); bus_addr = 2'd3; bus_wdata = b; bus_wr = 1'b1;
    @(posedge clk);
    ecfg = 0; s = b[7:6];
    if (s != 3) begin
      if (b[5:4] == 2'b00) freeze(s);
      else begin
        m_acc[s] = b[5:4]; m_mode[s] = b[3:1]; m_bcd[s] = b[0];
        m_wp[s] = 0; m_rp[s] = 0; m_cl[s] = 0; m_sl[s] = 0;
        ecfg = 1 << s;
      end
    end else begin
      for (int c = 0; c < 3; c++) if (b[c+1]) begin
        if (!b[5]) freeze(c);
        if (!b[4]) begin
          m_st[c] = (out_in[c] << 7) | (null_in[c] << 6) | (m_acc[c] << 4) | (m_mode[c] << 1) | m_bcd[c];
          m_sl[c] = 1;
        end
      end
    end
    #1;
    chk("R2", int'(cfg_wr), ecfg, "configuration pulse");
    chk("R3", int'(reload_load), 0, "no load on command");
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic dwr(int c, input logic [7:0] b, string r);
    int eload;
    @(negedge clk); bus_addr = 2'(c); bus_wdata = b; bus_wr = 1'b1;
    @(posedge clk);
    eload = 0;
    case (m_acc[c])
      1: begin m_rel[c] = b; eload = 1 << c; end
      2: begin m_rel[c] = b << 8; eload = 1 << c; end
      3: if (m_wp[c] == 0) begin m_lo[c] = b; m_wp[c] = 1; end
         else begin m_rel[c] = (b << 8) | m_lo[c]; m_wp[c] = 0; eload = 1 << c; end
      default: ;
    endcase
    #1;
    chk(r, int'(reload_load), eload, "load pulse");
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic drd(int c, string r, string what);
    int src, e;
    @(negedge clk); bus_addr = 2'(c); bus_rd = 1'b1;
    #1;
    src = m_cl[c] ? m_lat[c] : cnt[c];
    if (m_sl[c]) e = m_st[c];
    else if (m_acc[c] == 2 || (m_acc[c] == 3 && m_rp[c] == 1)) e = (src >> 8) & 255;
    else e = src & 255;
    chk(r, int'(bus_rdata), e, what);
    @(posedge clk);
    if (m_sl[c]) m_sl[c] = 0;
    else if (m_acc[c] == 3) begin
      if (m_rp[c] == 1) begin m_rp[c] = 0; m_cl[c] = 0; end else m_rp[c] = 1;
    end else m_cl[c] = 0;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00; bus_wr = 1'b0; bus_rd = 1'b0;
    out_in = 3'b000; null_in = 3'b000;
    cnt[0] = 16'h1A2B; cnt[1] = 16'h3C4D; cnt[2] = 16'h5E6F;
    for (int c = 0; c < 3; c++) begin
      m_acc[c] = 3; m_mode[c] = 0; m_bcd[c] = 0; m_rel[c] = 0; m_lo[c] = 0;
      m_wp[c] = 0; m_rp[c] = 0; m_lat[c] = 0; m_cl[c] = 0; m_sl[c] = 0; m_st[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run = 1;

    // R1: command address reads back zero
    @(negedge clk); bus_addr = 2'd3; #1;
    chk("R1", int'(bus_rdata), 0, "command port read");

    // R5: live reads after reset, low then high
    drd(0, "R5", "live low byte");
    drd(0, "R5", "live high byte");

    // R4: low/high reload assembly
    dwr(0, 8'h34, "R4");
    dwr(0, 8'h12, "R4");

    // R2 R3: low-only channel 1, mode 2, bcd 1
    cmd(8'h55);
    dwr(1, 8'hAB, "R3");
    drd(1, "R5", "low-only live read");
    // R3: high-only channel 2, mode 3
    cmd(8'hA6);
    dwr(2, 8'h7E, "R3");
    drd(2, "R5", "high-only live read");

    // R6: latch then change count
    cnt[0] = 16'hBEEF;
    cmd(8'h00);
    cnt[0] = 16'h1111;
    drd(0, "R6", "frozen low byte");
    drd(0, "R6", "frozen high byte");
    drd(0, "R6", "live after frozen read");
    drd(0, "R6", "live high after frozen read");

    // R10 R4: half-written reload interrupted by a new command
    dwr(0, 8'h99, "R4");
    cmd(8'h34);
    dwr(0, 8'h01, "R10");
    dwr(0, 8'h02, "R10");

    // R7 R8 R9: read-back of status and count on channels 0 and 2
    out_in = 3'b001; null_in = 3'b100;
    cnt[0] = 16'hC0DE; cnt[2] = 16'hF00D;
    cmd(8'hCA);
    out_in = 3'b110; cnt[0] = 16'h0000; cnt[2] = 16'h0000;
    drd(0, "R9", "status before count");
    drd(0, "R9", "count low after status");
    drd(0, "R9", "count high after status");
    drd(2, "R8", "status channel 2");
    drd(2, "R7", "frozen high byte channel 2");

    // R8: status-only read-back on channel 1
    null_in = 3'b010;
    cmd(8'hE4);
    drd(1, "R8", "status only");
    drd(1, "R8", "live after status consumed");

    // R7: count-only read-back on channels 1 and 2
    cnt[1] = 16'h4455; cnt[2] = 16'h6677;
    cmd(8'hDC);
    cnt[1] = 16'h0001; cnt[2] = 16'h0002;
    drd(1, "R7", "frozen low channel 1");
    drd(2, "R7", "frozen high channel 2");

    // R10: configuration releases a frozen count
    cnt[0] = 16'hAAAA;
    cmd(8'h00);
    cnt[0] = 16'h5566;
    cmd(8'h36);
    drd(0, "R10", "live after release low");
    drd(0, "R10", "live after release high");

    // R10: re-freeze after one byte resets read pointer
    cnt[0] = 16'h1357;
    cmd(8'h00);
    drd(0, "R6", "first frozen byte");
    cnt[0] = 16'h2468;
    cmd(8'h00);
    drd(0, "R10", "low byte after re-freeze");
    drd(0, "R10", "high byte after re-freeze");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule